// File: doc/BRIEF.md
# Operand Effective Address Sequencer

This unit sits between the opcode decoder and the data-access stage of an 8-bit accumulator CPU. When the decoder has identified an instruction's addressing mode, it pulses `start` with a mode code, the address of the opcode, and the current X and Y index values. The sequencer then fetches the one or two operand bytes that follow the opcode through a single synchronous read port. For the indirect mode it also fetches a second two-byte value through the pointer those operand bytes form. It then presents the resulting 16-bit effective address and the address of the next opcode.

The read port is synchronous. The sequencer drives `mem_rd` and `mem_addr` in one cycle, and the byte arrives on `mem_rdata` in the following cycle. Multi-byte values are stored low byte first. Zero-page forms wrap inside the first 256 bytes. All other address arithmetic wraps at 16 bits.

The block accepts one request at a time. While a sequence is running, `busy` is high and `start` is ignored. The result is marked by a single-cycle `done` pulse. The effective address and next PC stay on their outputs until the next request completes.

Top module: `oea_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no request pending, `busy`, `done` and `mem_rd` are low.
- R2: Mode code 0 (zero page): the effective address is {0x00, byte at PC+1}, and the next PC is PC+2. Code 7 behaves the same way.
- R3: Mode codes 1 (index X) and 2 (index Y), zero page indexed: the effective address is {0x00, (byte at PC+1 + index) mod 256}, so 0xFF plus 0x01 gives 0x0000. The next PC is PC+2.
- R4: Mode code 3 (absolute): the byte at PC+1 is the low address byte and the byte at PC+2 is the high address byte. The next PC is PC+3.
- R5: Mode codes 4 (index X) and 5 (index Y), absolute indexed: the index is added to the full 16-bit absolute address, with carry into the high byte and wrap from 0xFFFF to 0x0000. The next PC is PC+3.
- R6: Mode code 6 (indirect): the pointer is formed from the bytes at PC+1 (low) and PC+2 (high). The result is {byte at pointer+1, byte at pointer}, where pointer+1 wraps at 16 bits, so a pointer of 0xFFFF takes its high byte from 0x0000. The next PC is PC+3.
- R7: Reads are issued in the order PC+1, PC+2, pointer, pointer+1, one per cycle, with data taken the cycle after issue. Operand addresses wrap at 16 bits (PC 0xFFFE reads 0xFFFF and then 0x0000). No read is issued while idle.
- R8: `done` rises 2, 3 or 5 clock edges after the edge that samples `start`, for the zero-page, absolute and indirect families respectively. It stays high for exactly one cycle.
- R9: `start` has no effect from the edge that accepts a request up to and including the `done` cycle. Exactly one result is produced per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Request pulse, sampled while idle |
| mode | input | 3 | Addressing mode code (0..6, 7 acts as 0) |
| pc_in | input | 16 | Address of the opcode byte |
| x_idx | input | 8 | X index value, sampled with `start` |
| y_idx | input | 8 | Y index value, sampled with `start` |
| mem_rd | output | 1 | Read request |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Sequence in progress, including the `done` cycle |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 16 | Effective address, valid from `done` onwards |
| pc_next | output | 16 | Address of the next opcode, valid from `done` onwards |

## Verification
The assertions rely on the memory returning a byte for every cycle in which a read was issued. They also assume that `mode`, `pc_in` and the index inputs matter only in the cycle in which `start` is accepted. The bench's behavioural memory registers its data on every read, with no stall. The driver holds the request fields steady only for the accepting cycle. It raises `start` during busy periods only as a deliberate test that the request is ignored.

// File: rtl/oea_pkg.sv
package oea_pkg;

  typedef enum logic [2:0] {
    AM_ZP   = 3'd0,
    AM_ZPX  = 3'd1,
    AM_ZPY  = 3'd2,
    AM_ABS  = 3'd3,
    AM_ABSX = 3'd4,
    AM_ABSY = 3'd5,
    AM_IND  = 3'd6,
    AM_RSV  = 3'd7
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_LO,
    ST_FETCH_HI,
    ST_PTR_LO,
    ST_PTR_HI,
    ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    SEL_PC1,
    SEL_PC2,
    SEL_PTR,
    SEL_PTR1
  } asel_e;

  typedef enum logic [1:0] {
    EA_NONE,
    EA_PAGE0,
    EA_ABS,
    EA_IND
  } ea_src_e;

  typedef enum logic [1:0] {
    IX_NONE,
    IX_X,
    IX_Y
  } idx_src_e;

  function automatic logic is_page0(amode_e m);
    return (m == AM_ZP) || (m == AM_ZPX) || (m == AM_ZPY) || (m == AM_RSV);
  endfunction

  function automatic logic is_ind(amode_e m);
    return m == AM_IND;
  endfunction

  function automatic idx_src_e idx_of(amode_e m);
    case (m)
      AM_ZPX, AM_ABSX: return IX_X;
      AM_ZPY, AM_ABSY: return IX_Y;
      default:         return IX_NONE;
    endcase
  endfunction

endpackage

// File: rtl/oea_rst_sync.sv
module oea_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/oea_fsm.sv
module oea_fsm
  import oea_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  amode_e  mode_q,
  output logic    busy,
  output logic    done,
  output logic    accept,
  output logic    mem_rd,
  output asel_e   asel,
  output logic    cap_lo,
  output logic    cap_hi,
  output logic    cap_tlo,
  output ea_src_e ea_ld
);
  seq_state_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    accept  = 1'b0;
    mem_rd  = 1'b0;
    asel    = SEL_PC1;
    cap_lo  = 1'b0;
    cap_hi  = 1'b0;
    cap_tlo = 1'b0;
    ea_ld   = EA_NONE;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          accept = 1'b1;
          mem_rd = 1'b1;
          asel   = SEL_PC1;
          st_d   = ST_FETCH_LO;
        end
      end
      ST_FETCH_LO: begin
        cap_lo = 1'b1;
        if (is_page0(mode_q)) begin
          ea_ld = EA_PAGE0;
          st_d  = ST_DONE;
        end else begin
          mem_rd = 1'b1;
          asel   = SEL_PC2;
          st_d   = ST_FETCH_HI;
        end
      end
      ST_FETCH_HI: begin
        cap_hi = 1'b1;
        if (is_ind(mode_q)) begin
          mem_rd = 1'b1;
          asel   = SEL_PTR;
          st_d   = ST_PTR_LO;
        end else begin
          ea_ld = EA_ABS;
          st_d  = ST_DONE;
        end
      end
      ST_PTR_LO: begin
        cap_tlo = 1'b1;
        mem_rd  = 1'b1;
        asel    = SEL_PTR1;
        st_d    = ST_PTR_HI;
      end
      ST_PTR_HI: begin
        ea_ld = EA_IND;
        st_d  = ST_DONE;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign busy = (st_q != ST_IDLE);
  assign done = (st_q == ST_DONE);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R7
  idle_no_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |-> !mem_rd);

endmodule

// File: rtl/oea_ea_calc.sv
module oea_ea_calc #(
  parameter int DW = 8,
  parameter int AW = 2 * DW
) (
  input  logic [DW-1:0] op_byte,
  input  logic [DW-1:0] idx,
  input  logic [AW-1:0] op_word,
  input  logic [DW-1:0] tgt_lo,
  input  logic [DW-1:0] tgt_hi,
  output logic [AW-1:0] ea_page0,
  output logic [AW-1:0] ea_abs,
  output logic [AW-1:0] ea_ind
);
  localparam int HIW = AW - DW;

  logic [DW-1:0] page_sum;

  always_comb begin
    page_sum = op_byte + idx;
    ea_page0 = {{HIW{1'b0}}, page_sum};
    ea_abs   = op_word + {{HIW{1'b0}}, idx};
    ea_ind   = {tgt_hi[HIW-1:0], tgt_lo};
  end
endmodule

// File: rtl/oea_datapath.sv
module oea_datapath
  import oea_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  amode_e        mode_in,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] x_in,
  input  logic [DW-1:0] y_in,
  input  logic [DW-1:0] rdata,
  input  logic          mem_rd,
  input  asel_e         asel,
  input  logic          cap_lo,
  input  logic          cap_hi,
  input  logic          cap_tlo,
  input  ea_src_e       ea_ld,
  output amode_e        mode_q,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] pc_next
);
  localparam logic [AW-1:0] LEN_SHORT = AW'(2);
  localparam logic [AW-1:0] LEN_LONG  = AW'(3);
  localparam logic [AW-1:0] ONE       = AW'(1);

  amode_e        mode_d;
  logic [AW-1:0] pc_q, pc_d;
  logic [DW-1:0] idx_q, idx_d;
  logic [DW-1:0] lo_q, lo_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [DW-1:0] tlo_q, tlo_d;
  logic [AW-1:0] ea_q, ea_d;
  logic [AW-1:0] pcn_q, pcn_d;

  logic [AW-1:0] op_word;
  logic [AW-1:0] ea_page0, ea_abs, ea_ind;

  assign op_word = {rdata[AW-DW-1:0], lo_q};

  oea_ea_calc #(.DW(DW), .AW(AW)) u_calc (
    .op_byte  (rdata),
    .idx      (idx_q),
    .op_word  (op_word),
    .tgt_lo   (tlo_q),
    .tgt_hi   (rdata),
    .ea_page0 (ea_page0),
    .ea_abs   (ea_abs),
    .ea_ind   (ea_ind)
  );

  always_comb begin
    case (asel)
      SEL_PC1:  mem_addr = pc_in + ONE;
      SEL_PC2:  mem_addr = pc_q + LEN_SHORT;
      SEL_PTR:  mem_addr = op_word;
      SEL_PTR1: mem_addr = ptr_q + ONE;
      default:  mem_addr = pc_in + ONE;
    endcase
  end

  always_comb begin
    mode_d = mode_q;
    pc_d   = pc_q;
    idx_d  = idx_q;
    pcn_d  = pcn_q;
    lo_d   = lo_q;
    ptr_d  = ptr_q;
    tlo_d  = tlo_q;
    ea_d   = ea_q;
    if (accept) begin
      mode_d = mode_in;
      pc_d   = pc_in;
      case (idx_of(mode_in))
        IX_X:    idx_d = x_in;
        IX_Y:    idx_d = y_in;
        default: idx_d = '0;
      endcase
      pcn_d = pc_in + (is_page0(mode_in) ? LEN_SHORT : LEN_LONG);
    end
    if (cap_lo)  lo_d  = rdata;
    if (cap_hi)  ptr_d = op_word;
    if (cap_tlo) tlo_d = rdata;
    case (ea_ld)
      EA_PAGE0: ea_d = ea_page0;
      EA_ABS:   ea_d = ea_abs;
      EA_IND:   ea_d = ea_ind;
      default:  ea_d = ea_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= AM_ZP;
      pc_q   <= '0;
      idx_q  <= '0;
      pcn_q  <= '0;
      lo_q   <= '0;
      ptr_q  <= '0;
      tlo_q  <= '0;
      ea_q   <= '0;
    end else begin
      mode_q <= mode_d;
      pc_q   <= pc_d;
      idx_q  <= idx_d;
      pcn_q  <= pcn_d;
      lo_q   <= lo_d;
      ptr_q  <= ptr_d;
      tlo_q  <= tlo_d;
      ea_q   <= ea_d;
    end
  end

  assign ea      = ea_q;
  assign pc_next = pcn_q;

  // R7
  operand_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && asel == SEL_PC2) |-> mem_addr == $past(mem_addr) + ONE);

  // R6
  ptr_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && asel == SEL_PTR1) |-> mem_addr == $past(mem_addr) + ONE);

endmodule

// File: rtl/oea_seq.sv
module oea_seq
  import oea_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] x_idx,
  input  logic [DW-1:0] y_idx,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] pc_next
);
  logic    rst_n_s;
  logic    accept, cap_lo, cap_hi, cap_tlo;
  asel_e   asel;
  ea_src_e ea_ld;
  amode_e  mode_q;

  oea_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  oea_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .start   (start),
    .mode_q  (mode_q),
    .busy    (busy),
    .done    (done),
    .accept  (accept),
    .mem_rd  (mem_rd),
    .asel    (asel),
    .cap_lo  (cap_lo),
    .cap_hi  (cap_hi),
    .cap_tlo (cap_tlo),
    .ea_ld   (ea_ld)
  );

  oea_datapath #(.DW(DW), .AW(AW)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .accept   (accept),
    .mode_in  (amode_e'(mode)),
    .pc_in    (pc_in),
    .x_in     (x_idx),
    .y_in     (y_idx),
    .rdata    (mem_rdata),
    .mem_rd   (mem_rd),
    .asel     (asel),
    .cap_lo   (cap_lo),
    .cap_hi   (cap_hi),
    .cap_tlo  (cap_tlo),
    .ea_ld    (ea_ld),
    .mode_q   (mode_q),
    .mem_addr (mem_addr),
    .ea       (ea),
    .pc_next  (pc_next)
  );

  // R3
  page0_hi_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && is_page0(mode_q)) |-> ea[AW-1:DW] == '0);

  // R9
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (start && busy) |=> $stable(mode_q));

endmodule

// File: tb/tb_oea_seq.sv
module tb_oea_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  mode;
  logic [15:0] pc_in;
  logic [7:0]  x_idx, y_idx;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        busy, done;
  logic [15:0] ea, pc_next;

  always #5 clk = ~clk;

  oea_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pc_in(pc_in),
    .x_idx(x_idx), .y_idx(y_idx), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .ea(ea), .pc_next(pc_next)
  );

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;
  int pushed = 0;
  int seen = 0;
  bit finished = 0;
  bit mon_on = 0;
  bit prev_done = 0;

  logic [7:0] ovr [logic [15:0]];

  function automatic logic [7:0] rd_byte(logic [15:0] a);
    logic [7:0] t;
    if (ovr.exists(a)) return ovr[a];
    t = a[7:0] * 8'd13;
    return t ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd) mem_rdata <= rd_byte(mem_addr);
  end

  typedef struct {
    logic [15:0] ea;
    logic [15:0] pcn;
    int          lat;
    int          t0;
    string       tag;
    string       ptag;
  } exp_t;
  exp_t sb[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (done && prev_done) chk(0, "R8", "done wider than one cycle", 32'd1, 32'd0);
      if (done) begin
        seen++;
        if (sb.size() == 0) begin
          chk(0, "R9", "done without accepted request", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(ea == e.ea, e.tag, "effective address", 32'(ea), 32'(e.ea));
          chk(pc_next == e.pcn, e.ptag, "next pc", 32'(pc_next), 32'(e.pcn));
          chk((cyc - e.t0) == e.lat, "R8", "latency", 32'(cyc - e.t0), 32'(e.lat));
        end
      end
      prev_done = done;
    end
  end

  task automatic run(input logic [2:0] m, input logic [15:0] pc,
                     input logic [7:0] x, input logic [7:0] y, input string extra);
    exp_t e;
    logic [7:0] lo, hi, ix;
    logic [15:0] p;
    while (busy) @(negedge clk);
    lo = rd_byte(pc + 16'd1);
    hi = rd_byte(pc + 16'd2);
    ix = (m == 3'd1 || m == 3'd4) ? x : ((m == 3'd2 || m == 3'd5) ? y : 8'h00);
    case (m)
      3'd0, 3'd7: begin e.ea = {8'h00, lo}; e.lat = 2; e.tag = "R2"; end
      3'd1, 3'd2: begin e.ea = {8'h00, 8'(lo + ix)}; e.lat = 2; e.tag = "R3"; end
      3'd3: begin e.ea = {hi, lo}; e.lat = 3; e.tag = "R4"; end
      3'd4, 3'd5: begin e.ea = {hi, lo} + {8'h00, ix}; e.lat = 3; e.tag = "R5"; end
      default: begin
        p = {hi, lo};
        e.ea = {rd_byte(p + 16'd1), rd_byte(p)};
        e.lat = 5; e.tag = "R6";
      end
    endcase
    e.pcn  = pc + ((e.lat == 2) ? 16'd2 : 16'd3);
    e.ptag = (e.lat == 2) ? "R2" : "R4";
    e.tag  = {e.tag, extra};
    e.ptag = {e.ptag, extra};
    e.t0   = cyc;
    sb.push_back(e);
    pushed++;
    mode = m; pc_in = pc; x_idx = x; y_idx = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mode = 3'd0; pc_in = 16'h0; x_idx = 8'h0; y_idx = 8'h0;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = 3'd0; pc_in = 16'h0; x_idx = 8'h0; y_idx = 8'h0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy in reset", 32'(busy), 32'd0);
    chk(done == 1'b0, "R1", "done in reset", 32'(done), 32'd0);
    chk(mem_rd == 1'b0, "R1", "mem_rd in reset", 32'(mem_rd), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", 32'(busy), 32'd0);
    chk(done == 1'b0, "R1", "done after reset", 32'(done), 32'd0);
    chk(mem_rd == 1'b0, "R1", "mem_rd after reset", 32'(mem_rd), 32'd0);
    mon_on = 1;

    // R2 plain zero page
    run(3'd0, 16'h1230, 8'h11, 8'h22, "");
    // R3 wrap inside page zero
    ovr[16'h0201] = 8'hFF;
    run(3'd1, 16'h0200, 8'h01, 8'h77, " wrap");
    ovr[16'h0301] = 8'h80;
    run(3'd2, 16'h0300, 8'h33, 8'h90, " wrapY");
    // R4 low byte first
    ovr[16'h0401] = 8'h34; ovr[16'h0402] = 8'h12;
    run(3'd3, 16'h0400, 8'h05, 8'h06, "");
    // R5 carry into high byte and 16-bit wrap
    ovr[16'h0501] = 8'hFF; ovr[16'h0502] = 8'h12;
    run(3'd4, 16'h0500, 8'h01, 8'h00, " carry");
    ovr[16'h0601] = 8'hFF; ovr[16'h0602] = 8'hFF;
    run(3'd5, 16'h0600, 8'h00, 8'h02, " wrap16");
    // R6 indirect, normal pointer and pointer at 0xFFFF
    ovr[16'h0701] = 8'h34; ovr[16'h0702] = 8'h12;
    ovr[16'h1234] = 8'h56; ovr[16'h1235] = 8'h78;
    run(3'd6, 16'h0700, 8'h00, 8'h00, "");
    ovr[16'h0801] = 8'hFF; ovr[16'h0802] = 8'hFF;
    ovr[16'hFFFF] = 8'hAB; ovr[16'h0000] = 8'hCD;
    run(3'd6, 16'h0800, 8'h00, 8'h00, " ptrFFFF");
    // R7 operand fetch across the top of the address space
    run(3'd3, 16'hFFFE, 8'h00, 8'h00, " R7");
    // R9 starts while busy are ignored
    run(3'd6, 16'h0700, 8'h00, 8'h00, "");
    mode = 3'd0; pc_in = 16'h4444; start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    // mixed patterns
    for (int i = 0; i < 42; i++)
      run(3'(i % 7), 16'(i * 1237 + 99), 8'(i * 31), 8'(i * 17 + 5), "");
    while (busy || sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    // R9 one result per accepted request
    chk(seen == pushed, "R9", "result count", 32'(seen), 32'(pushed));
    // R7 idle issues no reads
    for (int k = 0; k < 3; k++) begin
      chk(mem_rd == 1'b0, "R7", "read while idle", 32'(mem_rd), 32'd0);
      @(negedge clk);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL R8 watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule